// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block is the transmit side of one serial channel. Software or a neighbouring bus block drops a byte into a single-entry holding register through a write strobe. The block sends that byte on a line that idles high. Each frame has a start bit, five to eight data bits sent least significant bit first, an optional extra bit and a stop interval. All timing comes from a one-cycle enable that pulses sixteen times per bit period. The block does not generate that enable itself.

Two small mode words shape the frame. The character word selects the data length, the kind of extra bit and its polarity. The line word selects the stop length in sixteenths of a bit and switches on gating by clear-to-send. A three-bit command port enables, disables and resets the transmitter, and also starts and stops a break. A four-bit status port reports, in fixed bit positions, whether the holding register can take a byte and whether everything has been sent.

Top module: `serial_tx_path`

## Requirements
- R1: After rst_ni is released the line output is high and all status bits are 0, because the transmitter starts disabled.
- R2: Status bit 2 (ready) is 1 when the transmitter is enabled and the holding register is free. Status bit 3 (empty) is 1 when the transmitter is also not sending. Bits 1:0 read 0. A data write while ready is low is ignored.
- R3: A frame is a low start bit lasting 16 ticks, then the data bits least significant first, each lasting 16 ticks. The length field char_mode_i[1:0] gives 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3.
- R4: With char_mode_i[3:2]=0 the extra bit is parity over the sent data bits. It is even when char_mode_i[4]=0 and odd when char_mode_i[4]=1.
- R5: With char_mode_i[3:2]=1 the extra bit is forced to the value of char_mode_i[4]: 0 gives space, 1 gives mark.
- R6: With char_mode_i[3:2]=2 no extra bit is sent.
- R7: With char_mode_i[3:2]=3 (multidrop) the extra bit is the address flag char_mode_i[4] as sampled when the byte is taken for sending. Later mode writes do not change it.
- R8: The stop interval is high and lasts 9+line_mode_i[2:0] ticks. When line_mode_i[3] is set, 16 more ticks are added.
- R9: With 5-bit characters the stop interval is a further 8 ticks longer.
- R10: When line_mode_i[4]=1 and cts_ni is high, no new frame starts. A pending byte starts once cts_ni goes low.
- R11: cmd_i=4 starts a break: the idle line is driven low and no frame starts. cmd_i=5 ends the break.
- R12: cmd_i=2 disables the transmitter. A frame in progress completes, and a byte still held is not sent until cmd_i=1 enables the transmitter again.
- R13: cmd_i=3 resets the transmitter. The frame in progress is aborted on the next cycle with the line at mark, the held byte is discarded and the transmitter is left disabled.
- R14: Frame timing advances only in cycles where tick16_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Enable that pulses 16 times per bit period |
| char_mode_we_i | input | 1 | Write strobe for the character mode word |
| char_mode_i | input | 5 | [1:0] length, [3:2] extra-bit kind, [4] polarity or address flag |
| line_mode_we_i | input | 1 | Write strobe for the line mode word |
| line_mode_i | input | 5 | [3:0] stop code, [4] clear-to-send gating |
| cmd_we_i | input | 1 | Command strobe |
| cmd_i | input | 3 | 1 enable, 2 disable, 3 reset, 4 break on, 5 break off |
| data_we_i | input | 1 | Holding register write strobe |
| data_i | input | 8 | Byte to send |
| cts_ni | input | 1 | Clear-to-send, active low |
| txd_o | output | 1 | Serial line, idles high |
| status_o | output | 4 | [3] empty, [2] ready, [1:0] zero |

## Verification
A wrong frame state or bit counter shows up on txd_o within one bit period as a bit that is shifted or wrongly valued. The bench samples every bit at its centre, so a single misplaced bit is caught. A wrong stop length or extra-bit flag changes the cycle on which the empty status rises. That cycle is compared exactly, so an off-by-one tick is visible at the end of each frame. A stuck holding flag, enable flag or break flag shows up within a cycle in the status bits, or as a frame that starts when it must not.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  localparam int CHAR_W    = 8;
  localparam int BIT_TICKS = 16;
  localparam int CNT_W     = $clog2(3 * BIT_TICKS);
  localparam int IDX_W     = $clog2(CHAR_W);

  localparam logic [2:0] CMD_ENABLE  = 3'd1;
  localparam logic [2:0] CMD_DISABLE = 3'd2;
  localparam logic [2:0] CMD_RESET   = 3'd3;
  localparam logic [2:0] CMD_BRK_ON  = 3'd4;
  localparam logic [2:0] CMD_BRK_OFF = 3'd5;

  localparam logic [1:0] XB_PARITY = 2'd0;
  localparam logic [1:0] XB_FORCED = 2'd1;
  localparam logic [1:0] XB_NONE   = 2'd2;
  localparam logic [1:0] XB_ADDR   = 2'd3;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_EXTRA, ST_STOP} tx_state_e;

  function automatic logic [CHAR_W-1:0] char_mask(input logic [1:0] len);
    return CHAR_W'((1 << (int'(len) + 5)) - 1);
  endfunction

  function automatic logic extra_bit(input logic [CHAR_W-1:0] d, input logic [1:0] kind,
                                     input logic pol);
    case (kind)
      XB_PARITY: return (^d) ^ pol;
      XB_NONE:   return 1'b0;
      default:   return pol;
    endcase
  endfunction

  // stop length in ticks: 9..16, +16 for long codes, +8 for 5-bit chars
  function automatic logic [CNT_W-1:0] stop_len(input logic [3:0] code, input logic [1:0] len);
    logic [CNT_W-1:0] s;
    s = CNT_W'(BIT_TICKS / 2 + 1) + CNT_W'(code[2:0]);
    if (code[3]) s = s + CNT_W'(BIT_TICKS);
    if (len == 2'd0) s = s + CNT_W'(BIT_TICKS / 2);
    return s;
  endfunction
endpackage

// File: rtl/tx_mode_regs.sv
module tx_mode_regs (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       char_we_i,
  input  logic [4:0] char_i,
  input  logic       line_we_i,
  input  logic [4:0] line_i,
  output logic [1:0] len_o,
  output logic [1:0] xb_kind_o,
  output logic       xb_pol_o,
  output logic [3:0] stop_code_o,
  output logic       cts_en_o
);
  logic [4:0] char_q, line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      char_q <= '0;
      line_q <= '0;
    end else begin
      if (char_we_i) char_q <= char_i;
      if (line_we_i) line_q <= line_i;
    end
  end

  assign len_o       = char_q[1:0];
  assign xb_kind_o   = char_q[3:2];
  assign xb_pol_o    = char_q[4];
  assign stop_code_o = line_q[3:0];
  assign cts_en_o    = line_q[4];
endmodule

// File: rtl/tx_hold_ctrl.sv
module tx_hold_ctrl
  import serial_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [2:0]        cmd_i,
  input  logic              data_we_i,
  input  logic [CHAR_W-1:0] data_i,
  input  logic              load_i,
  output logic              en_o,
  output logic              brk_o,
  output logic              full_o,
  output logic [CHAR_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      brk_o  <= 1'b0;
      full_o <= 1'b0;
      data_o <= '0;
    end else begin
      if (load_i) full_o <= 1'b0;
      if (data_we_i && en_o && !full_o) begin
        full_o <= 1'b1;
        data_o <= data_i;
      end
      if (cmd_we_i) begin
        case (cmd_i)
          CMD_ENABLE:  en_o <= 1'b1;
          CMD_DISABLE: en_o <= 1'b0;
          CMD_BRK_ON:  brk_o <= 1'b1;
          CMD_BRK_OFF: brk_o <= 1'b0;
          CMD_RESET: begin
            en_o   <= 1'b0;
            brk_o  <= 1'b0;
            full_o <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  p_write_fills_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && en_o && !full_o && !cmd_we_i) |=> full_o);
endmodule

// File: rtl/tx_frame_engine.sv
module tx_frame_engine
  import serial_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [CHAR_W-1:0] data_i,
  input  logic [1:0]        len_i,
  input  logic [1:0]        xb_kind_i,
  input  logic              xb_pol_i,
  input  logic [3:0]        stop_code_i,
  output logic              busy_o,
  output logic              txd_o
);
  tx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q, stop_q, bit_ticks;
  logic [IDX_W-1:0]  idx_q, last_q;
  logic [CHAR_W-1:0] shreg_q, masked;
  logic              xb_en_q, xb_q, bit_done;

  assign masked    = data_i & char_mask(len_i);
  assign bit_ticks = (state_q == ST_STOP) ? stop_q : CNT_W'(BIT_TICKS);
  assign bit_done  = tick_i && (cnt_q == bit_ticks - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      shreg_q <= '0;
      xb_en_q <= 1'b0;
      xb_q    <= 1'b0;
      stop_q  <= '0;
    end else if (abort_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (state_q == ST_IDLE) begin
      if (start_i) begin
        // frame settings are frozen here for the whole character
        state_q <= ST_START;
        cnt_q   <= '0;
        idx_q   <= '0;
        last_q  <= IDX_W'(len_i) + IDX_W'(4);
        shreg_q <= masked;
        xb_en_q <= (xb_kind_i != XB_NONE);
        xb_q    <= extra_bit(masked, xb_kind_i, xb_pol_i);
        stop_q  <= stop_len(stop_code_i, len_i);
      end
    end else if (tick_i) begin
      if (bit_done) begin
        cnt_q <= '0;
        case (state_q)
          ST_START: state_q <= ST_DATA;
          ST_DATA: begin
            if (idx_q == last_q) begin
              state_q <= xb_en_q ? ST_EXTRA : ST_STOP;
            end else begin
              idx_q   <= idx_q + 1'b1;
              shreg_q <= shreg_q >> 1;
            end
          end
          ST_EXTRA: state_q <= ST_STOP;
          default:  state_q <= ST_IDLE;
        endcase
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    case (state_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = shreg_q[0];
      ST_EXTRA: txd_o = xb_q;
      default:  txd_o = 1'b1;
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);

  p_tick_hold_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i && !abort_i) |=> ($stable(cnt_q) && $stable(state_q)));
  p_stop_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP) |-> txd_o);
endmodule

// File: rtl/serial_tx_path.sv
module serial_tx_path
  import serial_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick16_i,
  input  logic       char_mode_we_i,
  input  logic [4:0] char_mode_i,
  input  logic       line_mode_we_i,
  input  logic [4:0] line_mode_i,
  input  logic       cmd_we_i,
  input  logic [2:0] cmd_i,
  input  logic       data_we_i,
  input  logic [7:0] data_i,
  input  logic       cts_ni,
  output logic       txd_o,
  output logic [3:0] status_o
);
  logic [1:0]        len, xb_kind;
  logic              xb_pol, cts_en;
  logic [3:0]        stop_code;
  logic              en, brk, full, busy, eng_txd, abort, start, cts_ok;
  logic [CHAR_W-1:0] hold_data;

  tx_mode_regs u_mode (
    .clk_i, .rst_ni,
    .char_we_i(char_mode_we_i), .char_i(char_mode_i),
    .line_we_i(line_mode_we_i), .line_i(line_mode_i),
    .len_o(len), .xb_kind_o(xb_kind), .xb_pol_o(xb_pol),
    .stop_code_o(stop_code), .cts_en_o(cts_en)
  );

  tx_hold_ctrl u_hold (
    .clk_i, .rst_ni,
    .cmd_we_i, .cmd_i, .data_we_i, .data_i,
    .load_i(start), .en_o(en), .brk_o(brk), .full_o(full), .data_o(hold_data)
  );

  assign abort  = cmd_we_i && (cmd_i == CMD_RESET);
  assign cts_ok = !cts_en || !cts_ni;
  assign start  = en && full && !busy && !brk && cts_ok && !abort;

  tx_frame_engine u_eng (
    .clk_i, .rst_ni,
    .tick_i(tick16_i), .start_i(start), .abort_i(abort),
    .data_i(hold_data), .len_i(len), .xb_kind_i(xb_kind), .xb_pol_i(xb_pol),
    .stop_code_i(stop_code), .busy_o(busy), .txd_o(eng_txd)
  );

  assign txd_o    = busy ? eng_txd : !brk;
  assign status_o = {en && !full && !busy, en && !full, 2'b00};

  p_load_clears_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !full);
  p_start_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !txd_o);
  p_cts_block_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && cts_en && cts_ni) |=> !busy);
  p_break_block_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk && !busy) |=> !busy);
  p_reset_mark_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> (txd_o && !busy && status_o == 4'b0000));
endmodule

// File: tb/serial_tx_path_test.sv
module serial_tx_path_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       char_we = 1'b0, line_we = 1'b0, cmd_we = 1'b0, data_we = 1'b0;
  logic [4:0] char_m = '0, line_m = '0;
  logic [2:0] cmd = '0;
  logic [7:0] data = '0;
  logic       cts_n = 1'b0;
  logic       txd;
  logic [3:0] status;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic cap [0:511];

  serial_tx_path uut (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick),
    .char_mode_we_i(char_we), .char_mode_i(char_m),
    .line_mode_we_i(line_we), .line_mode_i(line_m),
    .cmd_we_i(cmd_we), .cmd_i(cmd), .data_we_i(data_we), .data_i(data),
    .cts_ni(cts_n), .txd_o(txd), .status_o(status)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [4:0] chr;
    logic [4:0] lin;
    logic [7:0] dat;
    logic [3:0] nbits;
    logic       has_xb;
    logic       xb;
    logic [5:0] stop;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{5'h03, 5'h07, 8'hA5, 4'd8, 1'b1, 1'b0, 6'd16},
    '{5'h13, 5'h0F, 8'hA5, 4'd8, 1'b1, 1'b1, 6'd32},
    '{5'h0A, 5'h00, 8'hFF, 4'd7, 1'b0, 1'b0, 6'd9},
    '{5'h15, 5'h03, 8'h2A, 4'd6, 1'b1, 1'b1, 6'd12},
    '{5'h04, 5'h07, 8'h13, 4'd5, 1'b1, 1'b0, 6'd24},
    '{5'h08, 5'h0F, 8'h1F, 4'd5, 1'b0, 1'b0, 6'd40},
    '{5'h11, 5'h08, 8'h3B, 4'd6, 1'b1, 1'b0, 6'd25},
    '{5'h02, 5'h05, 8'h81, 4'd7, 1'b1, 1'b1, 6'd14},
    '{5'h1F, 5'h07, 8'h00, 4'd8, 1'b1, 1'b1, 6'd16},
    '{5'h0F, 5'h0C, 8'hFF, 4'd8, 1'b1, 1'b0, 6'd29}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [7:0] v);
    @(negedge clk);
    case (sel)
      0: begin char_we = 1'b1; char_m = v[4:0]; end
      1: begin line_we = 1'b1; line_m = v[4:0]; end
      2: begin cmd_we = 1'b1; cmd = v[2:0]; end
      default: begin data_we = 1'b1; data = v; end
    endcase
    @(negedge clk);
    char_we = 1'b0; line_we = 1'b0; cmd_we = 1'b0; data_we = 1'b0;
  endtask

  task automatic wait_start(output bit ok);
    int w;
    w = 0;
    do begin @(negedge clk); w++; end while (txd !== 1'b0 && w < 40);
    ok = (txd === 1'b0);
    cap[0] = txd;
  endtask

  task automatic wait_empty();
    int w;
    w = 0;
    while (status[3] !== 1'b1 && w < 600) begin @(negedge clk); w++; end
  endtask

  // capture a frame at negedges; t_end = first t with empty high
  task automatic capture_frame(output int t_end);
    bit ok;
    t_end = -1;
    wait_start(ok);
    if (!ok) return;
    for (int t = 1; t < 500; t++) begin
      @(negedge clk);
      cap[t] = txd;
      if (status[3]) begin t_end = t; break; end
    end
  endtask

  task automatic check_frame(input vec_t v, input int t_end);
    logic [7:0] obs, exp_d;
    int p, t_exp;
    string xtag, stag;
    obs = '0;
    exp_d = v.dat & 8'((1 << v.nbits) - 1);
    for (int i = 0; i < int'(v.nbits); i++) obs[i] = cap[16*(i+1)+8];
    chk(cap[8] === 1'b0 && obs == exp_d, "R3", int'(obs), int'(exp_d));
    case (v.chr[3:2])
      2'd0: xtag = "R4";
      2'd1: xtag = "R5";
      2'd2: xtag = "R6";
      default: xtag = "R7";
    endcase
    p = v.has_xb ? 1 : 0;
    chk(cap[16*(v.nbits+1)+8] === (v.has_xb ? v.xb : 1'b1), xtag,
        int'(cap[16*(v.nbits+1)+8]), int'(v.has_xb ? v.xb : 1'b1));
    stag = (v.nbits == 4'd5) ? "R9" : "R8";
    t_exp = 16 * (1 + int'(v.nbits) + p) + int'(v.stop);
    chk(t_end == t_exp && cap[t_exp-1] === 1'b1 && cap[16*(1+int'(v.nbits)+p)] === 1'b1,
        stag, t_end, t_exp);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int t_end;
    bit ok, all_ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txd === 1'b1, "R1", int'(txd), 1);
    chk(status === 4'b0000, "R1", int'(status), 0);
    // R2 write while disabled is ignored
    wr(3, 8'h55);
    wr(2, 8'd1);
    chk(status === 4'b1100, "R2", int'(status), 12);
    repeat (30) @(negedge clk);
    chk(txd === 1'b1 && status === 4'b1100, "R2", int'(txd), 1);

    // table walk
    foreach (VECS[k]) begin
      wr(0, {3'b0, VECS[k].chr});
      wr(1, {3'b0, VECS[k].lin});
      wr(3, VECS[k].dat);
      capture_frame(t_end);
      check_frame(VECS[k], t_end);
    end

    // R7: mode change after load does not alter the address flag
    wr(0, 8'h1F); wr(1, 8'h07); wr(3, 8'h00);
    wait_start(ok);
    for (int t = 1; t < 400; t++) begin
      @(negedge clk);
      cap[t] = txd;
      char_we = (t == 2);
      char_m = 5'h0F;
      if (status[3]) break;
    end
    char_we = 1'b0;
    chk(cap[16*9+8] === 1'b1, "R7", int'(cap[16*9+8]), 1);

    // R13 reset command mid-frame
    wr(0, 8'h03); wr(1, 8'h07); wr(3, 8'h00);
    wait_start(ok);
    repeat (40) @(negedge clk);
    cmd_we = 1'b1; cmd = 3'd3;
    @(negedge clk);
    cmd_we = 1'b0;
    chk(txd === 1'b1 && status === 4'b0000, "R13", int'(status), 0);
    wr(2, 8'd1);
    chk(status === 4'b1100, "R13", int'(status), 12);
    all_ok = 1'b1;
    for (int t = 0; t < 40; t++) begin @(negedge clk); if (txd !== 1'b1) all_ok = 1'b0; end
    chk(all_ok, "R13", int'(all_ok), 1);

    // R12 disable lets frame finish, held byte waits
    wr(3, 8'h55);
    wait_start(ok);
    for (int t = 1; t < 400; t++) begin
      @(negedge clk);
      cap[t] = txd;
      data_we = 1'b0; cmd_we = 1'b0;
      if (t == 20) begin
        chk(status === 4'b0100, "R2", int'(status), 4);
        data_we = 1'b1; data = 8'h0F;
      end
      if (t == 22) chk(status === 4'b0000, "R2", int'(status), 0);
      if (t == 30) begin cmd_we = 1'b1; cmd = 3'd2; end
    end
    data_we = 1'b0; cmd_we = 1'b0;
    begin
      logic [7:0] obs;
      for (int i = 0; i < 8; i++) obs[i] = cap[16*(i+1)+8];
      all_ok = (obs == 8'h55) && (cap[16*9+8] === 1'b0);
      for (int t = 160; t < 400; t++) if (cap[t] !== 1'b1) all_ok = 1'b0;
      chk(all_ok, "R12", int'(obs), 8'h55);
    end
    wr(2, 8'd1);
    wait_start(ok);
    chk(ok, "R12", int'(ok), 1);
    wait_empty();

    // R10 clear-to-send gating
    wr(1, 8'h17);
    @(negedge clk); cts_n = 1'b1;
    wr(3, 8'h5A);
    all_ok = 1'b1;
    for (int t = 0; t < 60; t++) begin
      @(negedge clk);
      if (txd !== 1'b1 || status !== 4'b0000) all_ok = 1'b0;
    end
    chk(all_ok, "R10", int'(all_ok), 1);
    cts_n = 1'b0;
    wait_start(ok);
    chk(ok, "R10", int'(ok), 1);
    wait_empty();
    wr(1, 8'h07);

    // R11 break
    wr(2, 8'd4);
    all_ok = 1'b1;
    for (int t = 0; t < 40; t++) begin @(negedge clk); if (txd !== 1'b0) all_ok = 1'b0; end
    chk(all_ok, "R11", int'(all_ok), 1);
    wr(2, 8'd5);
    chk(txd === 1'b1, "R11", int'(txd), 1);

    // R14 no progress without tick
    wr(3, 8'h03);
    wait_start(ok);
    tick = 1'b0;
    t_end = -1;
    for (int t = 1; t < 500; t++) begin
      @(negedge clk);
      cap[t] = txd;
      if (t == 50) tick = 1'b1;
      if (status[3]) begin t_end = t; break; end
    end
    tick = 1'b1;
    all_ok = 1'b1;
    for (int t = 0; t < 66; t++) if (cap[t] !== 1'b0) all_ok = 1'b0;
    chk(all_ok && cap[74] === 1'b1, "R14", int'(all_ok), 1);
    chk(t_end == 226, "R14", t_end, 226);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule